// File: doc/BRIEF.md
# Coprocessor Execute Unit with Stage Counter

This block is the arithmetic stage of a small coprocessor. It holds four general registers and applies add, subtract, AND, OR, move and logical shifts to them. The second operand is either a register or an immediate field, chosen per instruction. The result is written back to a destination register on the clock edge that accepts the instruction, so the next instruction can read it at once.

Beside the general registers, the unit keeps an 8-bit stage counter. Only three dedicated operations touch it: step up by an immediate, step down by an immediate, and clear. A zero flag and a carry/borrow flag are captured from the most recent general operation. A later conditional branch tests these flags. Decode and branch logic sit outside this block. They drive one strobe per instruction with the operation code, the operand selects and the immediate.

Top module: `cop_alu`

## Requirements
- R1: After reset, every general register, `result_o`, `wr_en_o`, `zero_o`, `ovf_o` and `stage_o` are zero.
- R2: Add (code 0) gives A+B modulo 2^16 and sets `ovf_o` to the carry out. Subtract (code 1) gives A-B modulo 2^16 and sets `ovf_o` when A<B (borrow). `result_o` and the flags change on the same edge that samples `en_i`.
- R3: AND (code 2) and OR (code 3) give the bitwise result. For every general operation, `zero_o` is 1 exactly when the result is 0. For codes 2 to 6, `ovf_o` is 0.
- R4: Move (code 4) copies the immediate when `imm_sel_i`=1. When `imm_sel_i`=0, it copies register `src_a_i`.
- R5: Shift left (code 5) and shift right (code 6) are logical and shift A by B bits. A shift amount of 16 or more gives 0.
- R6: A is always register `src_a_i`. For codes 0 to 3, 5 and 6, B is `imm_i` when `imm_sel_i`=1 and register `src_b_i` otherwise. Each general operation writes register `dst_i` and pulses `wr_en_o` for one cycle. The next instruction reads the written value.
- R7: Stage increment (code 7) adds `imm_i[7:0]` and stage decrement (code 8) subtracts it, both wrapping modulo 256. Stage clear (code 9) sets the counter to 0. These operations write no register, keep `wr_en_o` low, and leave `result_o`, `zero_o` and `ovf_o` unchanged.
- R8: With `en_i`=0, or with codes 10 to 15, no register, output, flag or counter changes, and `wr_en_o` is 0.
- R9: Every operation code listed above takes effect within one clock edge, so back-to-back instructions need no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Instruction strobe |
| op_i | input | 4 | Operation code |
| imm_sel_i | input | 1 | 1: operand B is the immediate |
| dst_i | input | 2 | Destination register |
| src_a_i | input | 2 | Operand A register |
| src_b_i | input | 2 | Operand B register |
| imm_i | input | 16 | Immediate operand / stage step |
| result_o | output | 16 | Last general-operation result |
| wr_en_o | output | 1 | Register write happened on last edge |
| stage_o | output | 8 | Stage counter |
| zero_o | output | 1 | Last result was zero |
| ovf_o | output | 1 | Carry or borrow of last add/subtract |

## Verification
The bench builds the unit with its default values: 16-bit data, four registers and an 8-bit counter. With these values, every general operation code can be swept in both operand modes against ten boundary operands. The operands include 0, 0x7FFF, 0x8000, 0xFFFF and the shift limits 15, 16 and 17. Register pairs and destinations rotate, so the sweep covers overlap of destination and source. Stage steps are chosen to wrap the 8-bit counter in both directions.

// File: rtl/cop_alu_pkg.sv
package cop_alu_pkg;
  typedef enum logic [3:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_OR  = 4'd3,
    ALU_MOV = 4'd4,
    ALU_SHL = 4'd5,
    ALU_SHR = 4'd6,
    STG_INC = 4'd7,
    STG_DEC = 4'd8,
    STG_CLR = 4'd9
  } alu_op_e;

  function automatic logic is_gen_op(input logic [3:0] op);
    return op <= ALU_SHR;
  endfunction

  function automatic logic is_stg_op(input logic [3:0] op);
    return (op >= STG_INC) && (op <= STG_CLR);
  endfunction
endpackage

// File: rtl/cop_alu_regfile.sv
module cop_alu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R8: a register moves only under a write strobe
  p_reg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q[0]) && $stable(regs_q[NREG-1]));
endmodule

// File: rtl/cop_alu_core.sv
module cop_alu_core
  import cop_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SH_LIM = DATA_W'(DATA_W);

  logic [DATA_W:0] sum, diff;
  logic            sh_big;

  assign sum    = {1'b0, a_i} + {1'b0, b_i};
  assign diff   = {1'b0, a_i} - {1'b0, b_i};
  assign sh_big = (b_i >= SH_LIM);

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    unique case (op_i)
      ALU_ADD: begin res_o = sum[DATA_W-1:0];  ovf_o = sum[DATA_W];  end
      ALU_SUB: begin res_o = diff[DATA_W-1:0]; ovf_o = diff[DATA_W]; end
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_MOV: res_o = b_i;
      ALU_SHL: res_o = sh_big ? '0 : (a_i << b_i[SH_W-1:0]);
      ALU_SHR: res_o = sh_big ? '0 : (a_i >> b_i[SH_W-1:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/cop_alu_stage.sv
module cop_alu_stage
  import cop_alu_pkg::*;
#(
  parameter int STAGE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [3:0]         op_i,
  input  logic [STAGE_W-1:0] step_i,
  output logic [STAGE_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (en_i) begin
      unique case (op_i)
        STG_INC: cnt_o <= cnt_o + step_i;
        STG_DEC: cnt_o <= cnt_o - step_i;
        STG_CLR: cnt_o <= '0;
        default: ;
      endcase
    end
  end

  p_stage_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && is_stg_op(op_i)) |=> $stable(cnt_o));
  p_stage_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == STG_CLR) |=> (cnt_o == '0));
endmodule

// File: rtl/cop_alu.sv
module cop_alu
  import cop_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int STAGE_W = 8,
  localparam int AW     = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [3:0]         op_i,
  input  logic               imm_sel_i,
  input  logic [AW-1:0]      dst_i,
  input  logic [AW-1:0]      src_a_i,
  input  logic [AW-1:0]      src_b_i,
  input  logic [DATA_W-1:0]  imm_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_en_o,
  output logic [STAGE_W-1:0] stage_o,
  output logic               zero_o,
  output logic               ovf_o
);
  logic [DATA_W-1:0] rd_a, rd_b, opnd_b, res;
  logic              ovf, gen_go, stg_go;

  assign gen_go = en_i && is_gen_op(op_i);
  assign stg_go = en_i && is_stg_op(op_i);
  // register-mode move takes its source from port A
  assign opnd_b = imm_sel_i ? imm_i : ((op_i == ALU_MOV) ? rd_a : rd_b);

  cop_alu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i(gen_go), .waddr_i(dst_i), .wdata_i(res),
    .raddr_a_i(src_a_i), .raddr_b_i(src_b_i),
    .rdata_a_o(rd_a), .rdata_b_o(rd_b)
  );

  cop_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i, .a_i(rd_a), .b_i(opnd_b), .res_o(res), .ovf_o(ovf)
  );

  cop_alu_stage #(.STAGE_W(STAGE_W)) u_stage (
    .clk_i, .rst_ni, .en_i, .op_i,
    .step_i(imm_i[STAGE_W-1:0]), .cnt_o(stage_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= gen_go;
      if (gen_go) begin
        result_o <= res;
        zero_o   <= (res == '0);
        ovf_o    <= ovf;
      end
    end
  end

  p_idle_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wr_en_o);
  p_stage_side_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_go |=> !wr_en_o && $stable(result_o) && $stable(zero_o) && $stable(ovf_o));
  p_zero_tracks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (zero_o == (result_o == '0)));
  p_no_ovf_logic_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_go && op_i >= ALU_AND) |=> !ovf_o);
endmodule

// File: tb/cop_alu_tb_top.sv
`timescale 1ns/1ps
module cop_alu_tb_top;
  logic        clk = 0, rst_ni = 0;
  logic        en = 0, imm_sel = 0;
  logic [3:0]  op = 0;
  logic [1:0]  dst = 0, sa = 0, sb = 0;
  logic [15:0] imm = 0;
  logic [15:0] result;
  logic        wr_en, zero, ovf;
  logic [7:0]  stage;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_reg [4];
  logic [15:0] m_res;
  logic        m_z, m_o;
  logic [7:0]  m_stg;

  always #2.5 clk = ~clk;

  cop_alu dut_i (
    .clk_i(clk), .rst_ni, .en_i(en), .op_i(op), .imm_sel_i(imm_sel),
    .dst_i(dst), .src_a_i(sa), .src_b_i(sb), .imm_i(imm),
    .result_o(result), .wr_en_o(wr_en), .stage_o(stage), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input bit im, input logic [1:0] d, a_r, b_r,
                        input logic [15:0] iv, input bit e, input string tag);
    logic [15:0] a, b, r;
    logic [16:0] w;
    logic        v, we;
    a = m_reg[a_r];
    b = im ? iv : ((o == 4) ? m_reg[a_r] : m_reg[b_r]);
    r = '0; v = 0;
    case (o)
      0: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; v = w[16]; end
      1: begin r = a - b; v = (a < b); end
      2: r = a & b;
      3: r = a | b;
      4: r = b;
      5: r = (b > 15) ? 16'h0 : 16'(a << b);
      6: r = (b > 15) ? 16'h0 : 16'(a >> b);
      default: ;
    endcase
    we = e && (o <= 6);
    if (we) begin m_res = r; m_z = (r == 0); m_o = v; m_reg[d] = r; end
    else if (e && o == 7) m_stg = m_stg + iv[7:0];
    else if (e && o == 8) m_stg = m_stg - iv[7:0];
    else if (e && o == 9) m_stg = 8'h0;
    @(negedge clk);
    en = e; op = o; imm_sel = im; dst = d; sa = a_r; sb = b_r; imm = iv;
    @(negedge clk);
    en = 0;
    chk(result == m_res, {tag, " result"}, 32'(result), 32'(m_res));
    chk(wr_en == we,     {tag, " wr_en"},  32'(wr_en), 32'(we));
    chk(zero == m_z,     {tag, " zero"},   32'(zero), 32'(m_z));
    chk(ovf == m_o,      {tag, " ovf"},    32'(ovf), 32'(m_o));
    chk(stage == m_stg,  {tag, " stage"},  32'(stage), 32'(m_stg));
  endtask

  function automatic string op_tag(input int o);
    case (o)
      0, 1: return "R2 R9";
      2, 3: return "R3 R9";
      4: return "R4 R9";
      default: return "R5 R9";
    endcase
  endfunction

  initial begin
    logic [15:0] vals [10] = '{16'h0, 16'h1, 16'h2, 16'hf, 16'h10, 16'h11,
                               16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    for (int k = 0; k < 4; k++) m_reg[k] = 0;
    m_res = 0; m_z = 0; m_o = 0; m_stg = 0;
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk(result == 0 && wr_en == 0 && zero == 0 && ovf == 0 && stage == 0,
        "R1 reset outputs", {result, 7'b0, wr_en, zero, ovf, stage[5:0]}, 0);
    rst_ni = 1;
    // R1: registers read back zero through register-mode move
    for (int k = 0; k < 4; k++) run_op(4, 0, 2'(k), 2'(k), 0, 16'h0, 1, "R1 reg read");

    // R2..R6 sweep, both operand modes
    for (int o = 0; o <= 6; o++)
      for (int im = 0; im < 2; im++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++) begin
            logic [1:0] ra, rb, rd;
            ra = 2'(i % 4);
            rb = 2'((i + 1 + j % 3) % 4);
            rd = 2'(j % 4);
            run_op(4, 1, ra, 0, 0, vals[i], 1, "R4 setup");
            if (im == 0) run_op(4, 1, rb, 0, 0, vals[j], 1, "R6 setup");
            run_op(4'(o), bit'(im), rd, ra, rb, vals[j], 1,
                   {op_tag(o), (im != 0) ? " imm" : " R6 reg"});
          end

    // R6 back-to-back: chain add reading fresh result
    run_op(4, 1, 1, 0, 0, 16'hfffe, 1, "R6 chain");
    run_op(0, 1, 1, 1, 0, 16'h1, 1, "R6 chain");
    run_op(0, 1, 2, 1, 0, 16'h1, 1, "R6 chain wrap R2");

    // R7 stage counter with wrap both ways
    run_op(7, 1, 3, 0, 0, 16'h00c8, 1, "R7 inc");
    run_op(7, 1, 3, 0, 0, 16'hff64, 1, "R7 inc wrap");
    run_op(8, 1, 3, 0, 0, 16'h0032, 1, "R7 dec wrap");
    run_op(8, 0, 3, 0, 0, 16'h0001, 1, "R7 dec");
    run_op(4, 0, 3, 3, 0, 16'h0, 1, "R7 no reg write");
    run_op(7, 1, 0, 0, 0, 16'h0005, 1, "R7 inc");
    run_op(9, 1, 0, 0, 0, 16'h00ff, 1, "R7 clear");
    run_op(8, 1, 0, 0, 0, 16'h0001, 1, "R7 dec from 0");
    run_op(4, 0, 0, 0, 0, 16'h0, 1, "R7 no reg write");

    // R8: strobe low and unused codes leave everything unchanged
    run_op(4, 1, 2, 0, 0, 16'h00aa, 1, "R8 setup");
    run_op(0, 1, 2, 2, 0, 16'h0005, 0, "R8 idle");
    run_op(7, 1, 2, 2, 0, 16'h0005, 0, "R8 idle stage");
    for (int c = 10; c < 16; c++) run_op(4'(c), 1, 2, 2, 0, 16'h0033, 1, "R8 unused code");
    run_op(4, 0, 2, 2, 0, 16'h0, 1, "R8 reg kept");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule